// File: doc/BRIEF.md
# Capacitor-Array Successive-Approximation Sequencer

This block drives a binary-weighted capacitor-array converter through one conversion per start request. It first holds a sampling phase, during which every bottom plate sits on the analog input and the summing node is held at ground. It then runs a binary search, one capacitor per bit-cycle from the largest down to the smallest. Each trial puts the capacitor under test on the reference while the bits already decided keep their plates where they were left. The comparator reports whether the summing node is negative. A negative node means the input is above the trial level, so the bit is kept.

Each bit-cycle takes two clocks. In the first, the charge redistributes after the plate switch. In the second, the comparator settles, and its output is taken only on the edge that closes that clock. When the smallest capacitor has been decided, the word is loaded into the result register and a one-clock done strobe is given. The unit dummy capacitor is not driven by this block and never goes to the reference.

Top module: `cap_sar_ctrl`

## Requirements
- R1: After reset, sample_o, done_o, every bit of plate_ref_o and every bit of result_o are 0.
- R2: A start_i seen high on an edge while idle raises sample_o for exactly SAMPLE_CLKS clocks, beginning at that edge, and plate_ref_o stays all 0 throughout.
- R3: Once sampling ends, plate_ref_o holds only bit N-1 at 1 for two clocks. Bit N-1 drives the largest capacitor and bit 0 the smallest, and a 1 puts that plate on the reference.
- R4: A comparator value of 1 (summing node negative) on the edge that closes a trial keeps that bit at 1 on the reference. A value of 0 returns the plate to ground and sets the bit to 0.
- R5: Each later trial raises the next-smaller plate while every larger plate keeps its decided value.
- R6: Each bit-cycle lasts two clocks: a redistribution clock, then a comparison clock. cmp_neg_i is used only on the edge that ends the comparison clock and has no effect in any other clock.
- R7: The decision for bit 0 is taken SAMPLE_CLKS+2N edges after the start edge. On that same edge, result_o takes the converted word and done_o goes high for one clock. result_o then holds until the next conversion completes, and plate_ref_o returns to all 0.
- R8: start_i while a conversion is in progress is ignored: the conversion keeps its timing and result, and no further sampling phase follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Conversion request, acted on only while idle |
| cmp_neg_i | input | 1 | Comparator output, 1 when the summing node is negative |
| sample_o | output | 1 | Sampling phase: plates on input, node grounded |
| plate_ref_o | output | N | Per-capacitor bottom-plate select, 1 = reference, 0 = ground |
| result_o | output | N | Last converted word |
| done_o | output | 1 | One-clock strobe when result_o is updated |

## Verification
Several properties are checked on every cycle by assertions: plates stay grounded while sampling, plates hold still through each comparison clock, done lasts one clock, the result holds between strobes, and a start during the search never reopens sampling. Other behaviour can only be shown by the bench's scenarios against a behavioural array and comparator. That covers the converted word for every input level, the exact cycle of each plate pattern, and the fact that comparator values outside the comparison clock are ignored; the bench proves the last point by inverting the comparator in every other clock.

// File: rtl/cap_sar_pkg.sv
package cap_sar_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SAMPLE = 2'd1,
    PH_REDIST = 2'd2,
    PH_CMP    = 2'd3
  } sar_phase_e;
endpackage

// File: rtl/sar_phase_fsm.sv
module sar_phase_fsm
  import cap_sar_pkg::*;
#(
  parameter int N           = 4,
  parameter int SAMPLE_CLKS = 2,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1,
  localparam int CNT_W = (SAMPLE_CLKS > 1) ? $clog2(SAMPLE_CLKS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output sar_phase_e       phase_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             decide_o,
  output logic             last_o
);
  localparam logic [IDX_W-1:0] IDX_TOP  = IDX_W'(N - 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SAMPLE_CLKS - 1);

  sar_phase_e       ph_q, ph_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    ph_d  = ph_q;
    idx_d = idx_q;
    cnt_d = cnt_q;
    unique case (ph_q)
      PH_IDLE: if (start_i) begin
        ph_d  = PH_SAMPLE;
        cnt_d = '0;
      end
      PH_SAMPLE: begin
        if (cnt_q == CNT_LAST) begin
          ph_d  = PH_REDIST;
          idx_d = IDX_TOP;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_REDIST: ph_d = PH_CMP;
      PH_CMP: begin
        if (idx_q == '0) ph_d = PH_IDLE;
        else begin
          ph_d  = PH_REDIST;
          idx_d = idx_q - 1'b1;
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_IDLE;
      idx_q <= '0;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_d;
      idx_q <= idx_d;
      cnt_q <= cnt_d;
    end
  end

  assign phase_o  = ph_q;
  assign idx_o    = idx_q;
  assign decide_o = (ph_q == PH_CMP);
  assign last_o   = (idx_q == '0);

  // R8
  busy_start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && (ph_q == PH_REDIST || ph_q == PH_CMP)) |=> (ph_q != PH_SAMPLE));

  // R6
  redist_then_cmp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_REDIST) |=> (ph_q == PH_CMP && $stable(idx_q)));
endmodule

// File: rtl/sar_bit_reg.sv
module sar_bit_reg
  import cap_sar_pkg::*;
#(
  parameter int N = 4,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  sar_phase_e       phase_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             decide_i,
  input  logic             last_i,
  input  logic             cmp_neg_i,
  output logic [N-1:0]     plate_o,
  output logic [N-1:0]     result_o,
  output logic             done_o
);
  logic [N-1:0] dec_q, trial, dec_next;
  logic [N-1:0] res_q;
  logic         done_q;
  logic         active;

  assign active = (phase_i == PH_REDIST) || (phase_i == PH_CMP);

  for (genvar b = 0; b < N; b++) begin : g_bit
    assign trial[b]    = active && (idx_i == IDX_W'(b));
    assign dec_next[b] = trial[b] ? cmp_neg_i : dec_q[b];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_q  <= '0;
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= decide_i && last_i;
      if (phase_i == PH_SAMPLE) dec_q <= '0;
      else if (decide_i) dec_q <= dec_next;
      if (decide_i && last_i) res_q <= dec_next;
    end
  end

  assign plate_o  = active ? (dec_q | trial) : '0;
  assign result_o = res_q;
  assign done_o   = done_q;

  // R6
  plates_hold_in_cmp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == PH_CMP) |-> $stable(plate_o));

  // R7
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R7
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(result_o));
endmodule

// File: rtl/cap_sar_ctrl.sv
module cap_sar_ctrl
  import cap_sar_pkg::*;
#(
  parameter int N           = 4,
  parameter int SAMPLE_CLKS = 2,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         cmp_neg_i,
  output logic         sample_o,
  output logic [N-1:0] plate_ref_o,
  output logic [N-1:0] result_o,
  output logic         done_o
);
  sar_phase_e       phase;
  logic [IDX_W-1:0] idx;
  logic             decide, last;

  sar_phase_fsm #(.N(N), .SAMPLE_CLKS(SAMPLE_CLKS)) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .phase_o  (phase),
    .idx_o    (idx),
    .decide_o (decide),
    .last_o   (last)
  );

  sar_bit_reg #(.N(N)) u_bits (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .phase_i   (phase),
    .idx_i     (idx),
    .decide_i  (decide),
    .last_i    (last),
    .cmp_neg_i (cmp_neg_i),
    .plate_o   (plate_ref_o),
    .result_o  (result_o),
    .done_o    (done_o)
  );

  assign sample_o = (phase == PH_SAMPLE);

  // R2
  sample_plates_ground_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |-> (plate_ref_o == '0));

  // R7
  done_not_sampling_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!sample_o && plate_ref_o == '0));
endmodule

// File: tb/cap_sar_ctrl_bench.sv
module cap_sar_ctrl_bench;
  localparam int N = 4;
  localparam int S = 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         cmp_neg = 1'b0;
  logic         sample;
  logic [N-1:0] plate, result;
  logic         done;

  int errors = 0;
  int checks = 0;
  int exp_q[$];
  bit finished = 1'b0;

  always #2 clk = ~clk;

  cap_sar_ctrl #(.N(N), .SAMPLE_CLKS(S)) u_cap_sar_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cmp_neg_i(cmp_neg),
    .sample_o(sample), .plate_ref_o(plate), .result_o(result), .done_o(done)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural array: node = 2*dac - vin2, negative when input above trial level
  function automatic logic model_neg(input int vin2, input logic [N-1:0] p);
    return (2 * int'(p) - vin2) < 0;
  endfunction

  // monitor: pops expected words as done strobes appear
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) chk("R7 unexpected done", 1, 0);
      else chk("R4 R7 result word", int'(result), exp_q.pop_front());
    end
  end

  task automatic convert(input int vin2, input bit noise, input bit restart);
    int code;
    code = (vin2 - 1) / 2;
    exp_q.push_back(code);
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    for (int j = 0; j <= S + 2 * N; j++) begin
      @(negedge clk);
      start = restart && (j == S + 1 || j == S + 3);
      if (j < S) begin
        chk("R2 sample high", int'(sample), 1);
        chk("R2 plates grounded", int'(plate), 0);
        cmp_neg = noise;
      end else if (j < S + 2 * N) begin
        int i, p, expv;
        bit cmp_half;
        i = (j - S) / 2;
        p = N - 1 - i;
        cmp_half = ((j - S) % 2) == 1;
        expv = ((code >> (p + 1)) << (p + 1)) | (1 << p);
        chk("R6 sample low in search", int'(sample), 0);
        if (i == 0) chk("R3 MSB trial plates", int'(plate), expv);
        else chk("R5 trial keeps decisions", int'(plate), expv);
        chk("R7 done low mid search", int'(done), 0);
        cmp_neg = model_neg(vin2, plate) ^ (noise && !cmp_half);
      end else begin
        chk("R7 done strobe", int'(done), 1);
        chk("R7 plates released", int'(plate), 0);
        cmp_neg = noise;
      end
      if (j < S + 2 * N) @(posedge clk);
    end
    @(negedge clk);
    chk("R7 done one clock", int'(done), 0);
    chk("R8 no new sampling", int'(sample), 0);
    chk("R7 result held", int'(result), code);
    start = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 sample", int'(sample), 0);
    chk("R1 plates", int'(plate), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 result", int'(result), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after release", int'(sample), 0);
    // full sweep, clean comparator
    for (int c = 0; c < (1 << N); c++) convert(2 * c + 1, 1'b0, 1'b0);
    // comparator inverted outside comparison clocks (R6)
    convert(2 * 5 + 1, 1'b1, 1'b0);
    convert(2 * 10 + 1, 1'b1, 1'b0);
    convert(1, 1'b1, 1'b0);
    convert(2 * 15 + 1, 1'b1, 1'b0);
    // start pulses during search (R8)
    convert(2 * 9 + 1, 1'b0, 1'b1);
    convert(2 * 6 + 1, 1'b1, 1'b1);
    repeat (4) @(negedge clk);
    chk("R8 queue drained", exp_q.size(), 0);
    chk("R7 idle result held", int'(result), 6);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule